// File: doc/BRIEF.md
# Slot-Shared Single-Port Memory Scheduler

This block lets two requesters, a processor side and a graphics side, share one synchronous RAM while every register and the RAM itself run on the one fast system clock. A free-running counter advances on every fast clock, and one chosen bit of it serves as a slow timing signal. That bit is never routed to a clock pin. It is handled purely as data. Its level chooses which requester's address feeds the read port. A registered rising-edge detector on it produces a single-cycle write strobe, so that exactly one write is accepted per slow period.

Reads are synchronous with one cycle of latency. A registered owner tag leaves the block together with the read data, so each requester can tell which returned word belongs to it, even across a change of the slow bit. The write strobe is also driven out, so the writer can see the cycle in which its address and data were taken. The read and write ports are plain, always-accepting pins with no back-pressure. A requester holds its address steady for as long as it owns the port. The writer holds its address and data until it sees the strobe.

Top module: `shmem_slot_sched`

## Requirements
- R1: After a synchronous reset, the counter and the edge-detector history are zero, `rd_owner` is 0 and `wr_fire` is 0.
- R2: The counter increments on every clock after reset. The slow bit is counter bit `TAP`, so it is low for 2**TAP cycles and then high for 2**TAP cycles, starting low.
- R3: `wr_fire` is high for exactly one cycle per slow period: the cycle in which the slow bit is 1 and was 0 in the previous cycle. It is never high in the cycle after the slow bit falls, and never in any other cycle.
- R4: The RAM stores `wr_data` at `wr_addr` at the clock edge that ends a cycle with `wr_fire` high. Write inputs presented in any other cycle leave the memory unchanged.
- R5: In a cycle where the slow bit is 1, the read address is `cpu_addr`. Where it is 0, the read address is `gpu_addr`. The word at that address appears on `rd_data` one cycle later.
- R6: `rd_owner` is registered with the read and marks the owner of the word on `rd_data`: 1 means the processor side and 0 means the graphics side.
- R7: When a write and a read hit the same address in the same strobe cycle, the read returns the previous contents (read-first). A later read returns the new word.
- R8: The memory holds 2**ADDR_W words of DATA_W bits, and every address up to the top one is usable. The array has no reset, which keeps it inferable as dedicated block RAM. A full-size instance uses ADDR_W = 13 and DATA_W = 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; the only clock in the block |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Read address of the processor side, used while the slow bit is 1 |
| gpu_addr | input | ADDR_W | Read address of the graphics side, used while the slow bit is 0 |
| wr_addr | input | ADDR_W | Write address, taken in the strobe cycle |
| wr_data | input | DATA_W | Write data, taken in the strobe cycle |
| rd_data | output | DATA_W | Read word, one cycle after its address was selected |
| rd_owner | output | 1 | Owner of `rd_data`: 1 processor side, 0 graphics side |
| wr_fire | output | 1 | Write strobe, high for the one cycle per slow period in which the write is taken |

## Verification
The write strobe always falls in a cycle where the processor side owns the read port, so a write and a processor read can hit the same RAM word on the same edge. Once the write addresses start to recycle, the bench aims the processor read at the address being written in every third strobe cycle. The returned word must be the old contents, and a later read of that address must return the new word. The write inputs are also kept on the same address with junk data for the rest of each slow period, including the cycle after the falling edge. Every later read of such an address must still show the word written in the strobe cycle.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  typedef enum logic {
    OWN_GPU = 1'b0,
    OWN_CPU = 1'b1
  } owner_e;
endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int CNT_W = 24,
  parameter int TAP   = 23
) (
  input  logic clk,
  input  logic rst,
  output logic tap_bit
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign tap_bit = cnt[TAP];

  // R2: free-running step of one per clock
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == CNT_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (rst) level_d <= 1'b0;
    else     level_d <= level;
  end

  assign pulse = level & ~level_d;

  a_r3_single: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  a_r3_only_rise: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $rose(level));
  a_r3_not_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(level) |-> !pulse);
endmodule

// File: rtl/bram_1p.sv
module bram_1p #(
  parameter int AW = 13,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // no reset on the array or the output word: keeps block-RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];  // read-first on a same-address collision
  end
endmodule

// File: rtl/shmem_slot_sched.sv
module shmem_slot_sched #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int TAP    = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] gpu_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_owner,
  output logic              wr_fire
);
  import shmem_pkg::*;

  logic              slow_bit;
  logic              we_pulse;
  logic [ADDR_W-1:0] rd_addr;
  owner_e            owner_now;
  owner_e            owner_q;

  slot_counter #(.CNT_W(CNT_W), .TAP(TAP)) u_cnt (
    .clk(clk), .rst(rst), .tap_bit(slow_bit)
  );

  rise_detect u_edge (
    .clk(clk), .rst(rst), .level(slow_bit), .pulse(we_pulse)
  );

  assign owner_now = slow_bit ? OWN_CPU : OWN_GPU;
  assign rd_addr   = (owner_now == OWN_CPU) ? cpu_addr : gpu_addr;

  bram_1p #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .we(we_pulse), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_GPU;
    else     owner_q <= owner_now;
  end

  assign rd_owner = owner_q;
  assign wr_fire  = we_pulse;

  // R6: tag follows the slot that issued the read one cycle earlier
  a_r6_tag_follows: assert property (@(posedge clk) disable iff (rst)
    rd_owner == $past(slow_bit));
  // R3: the write strobe only occurs while the processor side owns the port
  a_r3_fire_in_cpu_slot: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> rd_owner);
endmodule

// File: tb/shmem_slot_sched_test.sv
module shmem_slot_sched_test;
  localparam int AW    = 11;
  localparam int DW    = 32;
  localparam int CW    = 8;
  localparam int TP    = 2;
  localparam int SLOTS = 130;

  typedef struct {
    bit          owner;
    bit          known;
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cpu_addr = '0, gpu_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_owner, wr_fire;

  int   vectors = 0, miscompares = 0, n = 0;
  bit   done = 0;
  exp_t scb[$];
  logic [31:0] model [int];

  always #2 clk = ~clk;

  shmem_slot_sched #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .TAP(TP)) uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .gpu_addr(gpu_addr),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data),
    .rd_owner(rd_owner), .wr_fire(wr_fire)
  );

  function automatic bit slowb(int k);
    if (k < 0) return 1'b0;
    return 1'(((k % (1 << CW)) >> TP) & 1);
  endfunction

  function automatic bit pulse(int k);
    return slowb(k) && !slowb(k - 1);
  endfunction

  function automatic int idx(int k);
    return (k < 1) ? 0 : ((k - 1) % 40) + 1;
  endfunction

  function automatic logic [AW-1:0] addr_of(int i);
    if (i == 40) return AW'((1 << AW) - 1);
    return AW'((i * 53 + 7) % (1 << AW));
  endfunction

  function automatic logic [31:0] good(int k);
    return {k[15:0], ~k[15:0]} ^ 32'h5A00_00A5;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, n);
    end
  endtask

  // driver: choose inputs for cycle n, push the expected read result
  task automatic drive();
    int   k = (n + 4) >> (TP + 1);
    int   span = (k > 2) ? k - 1 : 1;
    bit   p = pulse(n);
    exp_t e;
    logic [AW-1:0] wa = addr_of(idx(k));
    logic [AW-1:0] ca = addr_of(idx(1 + (n * 7) % span));
    logic [AW-1:0] ga = addr_of(idx(1 + (n * 11) % span));
    e.tag = "R5";
    if (p && k >= 41 && k % 3 == 0) begin
      ca = wa;
      e.tag = "R7";
    end else if (ca == addr_of(40) || ga == addr_of(40)) begin
      e.tag = "R8 R5";
    end else begin
      e.tag = "R4 R5";
    end
    wr_addr  = wa;
    wr_data  = p ? good(k) : (32'hDEAD_0000 | 32'(n));
    cpu_addr = ca;
    gpu_addr = ga;
    e.owner = slowb(n);
    begin
      logic [AW-1:0] ra = e.owner ? ca : ga;
      e.known = model.exists(int'(ra));
      e.data  = e.known ? model[int'(ra)] : 32'h0;
    end
    scb.push_back(e);
    if (p) model[int'(wa)] = good(k);
  endtask

  // monitor: pop and compare the read issued one cycle earlier
  task automatic monitor();
    exp_t e = scb.pop_front();
    check("R6 owner", {31'b0, rd_owner}, {31'b0, e.owner});
    if (e.known) check(e.tag, rd_data, e.data);
    check("R2 R3 wr_fire", {31'b0, wr_fire}, {31'b0, pulse(n)});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    n = 0;
    // R1: reset state
    check("R1 owner", {31'b0, rd_owner}, 32'h0);
    check("R1 wr_fire", {31'b0, wr_fire}, 32'h0);
    drive();
    for (int c = 0; c < SLOTS * (1 << (TP + 1)); c++) begin
      @(negedge clk);
      n++;
      monitor();
      drive();
    end
    // directed readback of top address and the first recycled words
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      n++;
      monitor();
      begin
        exp_t e;
        logic [AW-1:0] a = addr_of(j);
        cpu_addr = a;
        gpu_addr = a;
        wr_addr  = a;
        wr_data  = 32'hBAD0_0000 | 32'(j);
        e.owner = slowb(n);
        e.known = model.exists(int'(a));
        e.data  = e.known ? model[int'(a)] : 32'h0;
        e.tag   = (j == 40) ? "R8 readback" : "R4 readback";
        if (pulse(n)) model[int'(a)] = wr_data;
        scb.push_back(e);
      end
    end
    @(negedge clk);
    n++;
    monitor();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule